// File: doc/BRIEF.md
# Peripheral Control Register Bank

This block is the memory-mapped register file that sits between a processor bus and the on-chip video, sound, DMA, timer, serial and interrupt logic of a small handheld-style system. It holds 64 halfword registers behind a 7-bit byte address. It accepts byte, halfword and word writes and halfword reads. Each register applies its own write rule: a write mask, write-one-to-clear, read-as-zero or a live read. Writes that matter to an engine outside the bank come out as one-cycle strobes with the value attached. The engines themselves are not part of the block.

A byte write is merged into its halfword before the normal rules apply. A word write splits into two halfword writes in the same cycle. The exception is a DMA address word, which is forwarded whole as one 32-bit update. A dedicated odd byte address works as a halt port. A read returns its data one cycle after it is issued. An access to an address outside the decoded set still works as plain storage, and it raises a one-cycle error pulse.

Top module: `iobank_regs`

## Requirements
- R1: After reset, the display control register (byte 0x00) reads 0x0080, the sound level register (0x04) reads 0x0200, and every other stored register reads 0x0000.
- R2: A write to the display status register (0x02) stores the value ANDed with 0xFFF8, so bits 2:0 always read 0.
- R3: Writing the interrupt flag register (0x72) clears every stored bit that is 1 in the written value and keeps the rest. Bits high on `irq_raise_i` are set in the same cycle and win over a clear.
- R4: Timer t has a reload register at 0x50+4t and a control register at 0x52+4t. The control register stores only the bits in 0x00C7. A write to the reload register pulses `tmr_reload_we_o[t]`, with the written halfword on `tmr_reload_o`.
- R5: `wr_size_i` selects the write size: 0 is byte, 1 is halfword (address bit 0 ignored), 2 is word (address bits 1:0 ignored, low halfword to the lower address). A byte write replaces the lane chosen by address bit 0 (1 = bits 15:8). The other lane keeps its stored value, and the merged halfword then takes the normal write path.
- R6: A byte write to address 0x7F looks only at data bit 7. If that bit is 0, `halt_req_o` is high for exactly the next cycle. If it is 1, nothing happens. Neither case updates any register.
- R7: The DMA count registers at 0x18+0x10c (c = 0..3) are write-only and always read 0x0000.
- R8: The key register (0x62) reads 0x3FF XOR `keys_i` (bits 15:10 zero). Writes to it have no effect.
- R9: Each DMA channel c has its source address at 0x10+0x10c (low half) and 0x12+0x10c (high half), and its destination at +0x14 and +0x16. A halfword or byte write to one half is joined with the stored other half. A word write at the low half supplies both halves. Either way, the 32-bit result goes out on `dma_addr_o` with a one-cycle pulse on `dma_src_we_o[c]` or `dma_dst_we_o[c]`.
- R10: The serial mode register (0x60) stores only the bits in 0xC1FF. The interrupt master enable (0x74) stores only bit 0.
- R11: The valid set is 0x00–0x05, the DMA blocks (0x10+0x10c to 0x1B+0x10c), 0x50–0x63 and 0x70–0x75, plus the 0x7F halt port. Any other address stores and reads back the full halfword, and `err_o` pulses high for one cycle after the access.
- R12: `rdata_o` presents the read value one cycle after `rd_en_i` and holds it otherwise. If `wr_en_i` and `rd_en_i` are both high, only the write is performed. Every strobe output is high for exactly the cycle after its write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write request this cycle |
| wr_size_i | input | 2 | Write size: 0 byte, 1 halfword, 2 word |
| rd_en_i | input | 1 | Read request this cycle |
| addr_i | input | 7 | Byte address |
| wdata_i | input | 32 | Write data (byte in 7:0, halfword in 15:0) |
| irq_raise_i | input | 16 | Interrupt flag set pulses |
| keys_i | input | 10 | Live button levels, 1 = pressed |
| rdata_o | output | 16 | Read data, one cycle after the read |
| err_o | output | 1 | Access to an undecoded address |
| halt_req_o | output | 1 | Halt request pulse |
| dma_src_we_o | output | 4 | Per-channel source address update strobe |
| dma_dst_we_o | output | 4 | Per-channel destination address update strobe |
| dma_addr_o | output | 32 | Address carried by the DMA strobes |
| tmr_reload_we_o | output | 4 | Per-timer reload write strobe |
| tmr_reload_o | output | 16 | Reload value carried by the timer strobes |

## Verification
All results of an access are registered exactly once: read data, the error pulse, and the halt, DMA and timer strobes. They are therefore due in the cycle after the edge that accepts the request. Stored register contents become visible through a read issued in any later cycle. The bench drives each request on a falling edge and samples every output on the next falling edge. That is half a cycle after the capturing edge, and before the following one clears the strobes. Expected values come from a halfword model in the bench, which is updated from R1–R12 as each write is issued.

// File: rtl/iobank_pkg.sv
package iobank_pkg;

    localparam int ADDR_W     = 7;
    localparam int IDX_W      = ADDR_W - 1;
    localparam int NREG       = 2 ** IDX_W;
    localparam int HW         = 16;
    localparam int NDMA       = 4;
    localparam int NTMR       = 4;
    localparam int KEY_W      = 10;
    localparam int DMA_BASE   = 8;
    localparam int DMA_STRIDE = 8;
    localparam int DMA_REGS   = 6;
    localparam int DMA_CNT    = 4;
    localparam int TMR_BASE   = 40;
    localparam int IX_DCTRL   = 0;
    localparam int IX_DSTAT   = 1;
    localparam int IX_SBIAS   = 2;
    localparam int IX_SER     = 48;
    localparam int IX_KEYS    = 49;
    localparam int IX_IEN     = 56;
    localparam int IX_IFLG    = 57;
    localparam int IX_IMST    = 58;
    localparam logic [ADDR_W-1:0] HALT_ADDR = 7'h7F;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [HW-1:0]    hw_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef struct packed {
        logic en;
        idx_t idx;
        hw_t  val;
    } lane_t;

    typedef struct packed {
        logic [NDMA-1:0] src_we;
        logic [NDMA-1:0] dst_we;
        logic [31:0]     addr;
        logic [NTMR-1:0] tmr_we;
        hw_t             tmr_val;
        logic            halt;
        logic            err;
    } side_t;

    function automatic logic in_dma(idx_t i);
        return int'(i) >= DMA_BASE && int'(i) < DMA_BASE + NDMA * DMA_STRIDE
            && ((int'(i) - DMA_BASE) % DMA_STRIDE) < DMA_REGS;
    endfunction

    function automatic int dma_off(idx_t i);
        return (int'(i) - DMA_BASE) % DMA_STRIDE;
    endfunction

    function automatic int dma_ch(idx_t i);
        return (int'(i) - DMA_BASE) / DMA_STRIDE;
    endfunction

    function automatic logic in_tmr(idx_t i);
        return int'(i) >= TMR_BASE && int'(i) < TMR_BASE + 2 * NTMR;
    endfunction

    function automatic logic is_valid(idx_t i);
        return in_dma(i) || in_tmr(i)
            || int'(i) <= IX_SBIAS
            || int'(i) == IX_SER || int'(i) == IX_KEYS
            || (int'(i) >= IX_IEN && int'(i) <= IX_IMST);
    endfunction

    function automatic hw_t wmask(idx_t i);
        if (int'(i) == IX_DSTAT)      return 16'hFFF8;
        if (in_tmr(i) && i[0])        return 16'h00C7;
        if (int'(i) == IX_SER)        return 16'hC1FF;
        if (int'(i) == IX_IMST)       return 16'h0001;
        return 16'hFFFF;
    endfunction

    function automatic hw_t rst_val(idx_t i);
        if (int'(i) == IX_DCTRL)      return 16'h0080;
        if (int'(i) == IX_SBIAS)      return 16'h0200;
        if (int'(i) == IX_KEYS)       return 16'h03FF;
        return 16'h0000;
    endfunction

    // stored result of one halfword lane landing on register i
    function automatic hw_t wr_apply(idx_t i, hw_t old, hw_t v);
        if (int'(i) == IX_IFLG)       return old & ~v;
        if (int'(i) == IX_KEYS)       return old;
        return v & wmask(i);
    endfunction

endpackage

// File: rtl/iobank_merge.sv
module iobank_merge
    import iobank_pkg::*;
(
    input  logic              wr_en_i,
    input  size_e             wr_size_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  hw_t               hw_q [NREG],
    output lane_t             lane0_o,
    output lane_t             lane1_o,
    output side_t             side_o
);

    idx_t ix_h;
    idx_t ix_w;
    hw_t  cur;
    hw_t  part;
    int   ch;
    int   off;

    assign ix_h = addr_i[ADDR_W-1:1];
    assign ix_w = {addr_i[ADDR_W-1:2], 1'b0};

    always_comb begin
        lane0_o = '0;
        lane1_o = '0;
        side_o  = '0;
        cur     = hw_q[ix_h];
        part    = '0;
        ch      = 0;
        off     = 0;
        if (wr_en_i) begin
            if (wr_size_i == SZ_BYTE && addr_i == HALT_ADDR) begin
                side_o.halt = !wdata_i[7];
            end else begin
                case (wr_size_i)
                    SZ_BYTE: lane0_o = '{en: 1'b1, idx: ix_h,
                                         val: addr_i[0] ? {wdata_i[7:0], cur[7:0]}
                                                        : {cur[15:8], wdata_i[7:0]}};
                    SZ_WORD: begin
                        lane0_o = '{en: 1'b1, idx: ix_w, val: wdata_i[15:0]};
                        lane1_o = '{en: 1'b1, idx: idx_t'(ix_w + 1'b1), val: wdata_i[31:16]};
                    end
                    default: lane0_o = '{en: 1'b1, idx: ix_h, val: wdata_i[15:0]};
                endcase
                side_o.err = !is_valid(lane0_o.idx) || (lane1_o.en && !is_valid(lane1_o.idx));
                if (in_dma(lane0_o.idx) && dma_off(lane0_o.idx) < DMA_CNT) begin
                    ch  = dma_ch(lane0_o.idx);
                    off = dma_off(lane0_o.idx);
                    if (lane1_o.en) begin
                        side_o.addr = {lane1_o.val, lane0_o.val};
                    end else if (lane0_o.idx[0] == 1'b0) begin
                        part        = hw_q[idx_t'(lane0_o.idx + 1'b1)];
                        side_o.addr = {part, lane0_o.val};
                    end else begin
                        part        = hw_q[idx_t'(lane0_o.idx - 1'b1)];
                        side_o.addr = {lane0_o.val, part};
                    end
                    if (off < 2) side_o.src_we = NDMA'(1) << ch;
                    else         side_o.dst_we = NDMA'(1) << ch;
                end
                if (in_tmr(lane0_o.idx) && !lane0_o.idx[0]) begin
                    side_o.tmr_we  = NTMR'(1) << ((int'(lane0_o.idx) - TMR_BASE) / 2);
                    side_o.tmr_val = lane0_o.val;
                end
            end
        end else if (rd_en_i) begin
            side_o.err = !is_valid(ix_h);
        end
    end

endmodule

// File: rtl/iobank_regfile.sv
module iobank_regfile
    import iobank_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  lane_t            lane0_i,
    input  lane_t            lane1_i,
    input  hw_t              irq_raise_i,
    input  logic             rd_en_i,
    input  idx_t             rd_idx_i,
    input  logic [KEY_W-1:0] keys_i,
    output hw_t              hw_q [NREG],
    output hw_t              rdata_o
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam idx_t GI = idx_t'(g);
        hw_t r;
        hw_t d;

        always_comb begin
            d = r;
            if (lane0_i.en && lane0_i.idx == GI) d = wr_apply(GI, r, lane0_i.val);
            if (lane1_i.en && lane1_i.idx == GI) d = wr_apply(GI, r, lane1_i.val);
            if (g == IX_IFLG)                    d = d | irq_raise_i;
        end

        always_ff @(posedge clk_i) begin
            if (rst_i) r <= rst_val(GI);
            else       r <= d;
        end

        assign hw_q[g] = r;
    end

    hw_t rd_val;

    always_comb begin
        rd_val = hw_q[rd_idx_i];
        if (int'(rd_idx_i) == IX_KEYS)
            rd_val = 16'h03FF ^ {{(HW-KEY_W){1'b0}}, keys_i};
        else if (in_dma(rd_idx_i) && dma_off(rd_idx_i) == DMA_CNT)
            rd_val = '0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)        rdata_o <= '0;
        else if (rd_en_i) rdata_o <= rd_val;
    end

    // R2: status bits 2:0 never hold a written 1
    a_r2_stat_low_clear: assert property (@(posedge clk_i) disable iff (rst_i)
        hw_q[IX_DSTAT][2:0] == 3'b000);

    // R3: a flag bit only turns on through the raise input
    a_r3_flag_set_source: assert property (@(posedge clk_i) disable iff (rst_i)
        (hw_q[IX_IFLG] & ~$past(hw_q[IX_IFLG]) & ~$past(irq_raise_i)) == 16'h0000);

    // R4: timer control keeps only its defined bits
    for (genvar t = 0; t < NTMR; t++) begin : g_tchk
        a_r4_tctl_mask: assert property (@(posedge clk_i) disable iff (rst_i)
            (hw_q[TMR_BASE + 2*t + 1] & ~16'h00C7) == 16'h0000);
    end

endmodule

// File: rtl/iobank_strobe.sv
module iobank_strobe
    import iobank_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  side_t side_d_i,
    output side_t side_q_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) side_q_o <= '0;
        else       side_q_o <= side_d_i;
    end

    // R12: strobes last one cycle unless re-requested
    a_r12_strobe_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        (side_q_o.halt && !side_d_i.halt) |=> !side_q_o.halt);

endmodule

// File: rtl/iobank_regs.sv
module iobank_regs
    import iobank_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        wr_en_i,
    input  logic [1:0]  wr_size_i,
    input  logic        rd_en_i,
    input  logic [6:0]  addr_i,
    input  logic [31:0] wdata_i,
    input  logic [15:0] irq_raise_i,
    input  logic [9:0]  keys_i,
    output logic [15:0] rdata_o,
    output logic        err_o,
    output logic        halt_req_o,
    output logic [3:0]  dma_src_we_o,
    output logic [3:0]  dma_dst_we_o,
    output logic [31:0] dma_addr_o,
    output logic [3:0]  tmr_reload_we_o,
    output logic [15:0] tmr_reload_o
);

    lane_t lane0;
    lane_t lane1;
    side_t side_d;
    side_t side_q;
    hw_t   hw_q [NREG];
    logic  rd_go;

    assign rd_go = rd_en_i && !wr_en_i;

    iobank_merge u_merge (
        .wr_en_i  (wr_en_i),
        .wr_size_i(size_e'(wr_size_i)),
        .rd_en_i  (rd_en_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .hw_q     (hw_q),
        .lane0_o  (lane0),
        .lane1_o  (lane1),
        .side_o   (side_d)
    );

    iobank_regfile u_regfile (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .lane0_i    (lane0),
        .lane1_i    (lane1),
        .irq_raise_i(irq_raise_i),
        .rd_en_i    (rd_go),
        .rd_idx_i   (addr_i[ADDR_W-1:1]),
        .keys_i     (keys_i),
        .hw_q       (hw_q),
        .rdata_o    (rdata_o)
    );

    iobank_strobe u_strobe (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .side_d_i(side_d),
        .side_q_o(side_q)
    );

    assign err_o           = side_q.err;
    assign halt_req_o      = side_q.halt;
    assign dma_src_we_o    = side_q.src_we;
    assign dma_dst_we_o    = side_q.dst_we;
    assign dma_addr_o      = side_q.addr;
    assign tmr_reload_we_o = side_q.tmr_we;
    assign tmr_reload_o    = side_q.tmr_val;

    // R6: halt pulse follows exactly a bit-7-clear byte write to the port
    a_r6_halt_follows: assert property (@(posedge clk_i) disable iff (rst_i)
        halt_req_o == $past(wr_en_i && wr_size_i == 2'd0 && addr_i == HALT_ADDR && !wdata_i[7]));

    // R9: at most one DMA address update per cycle
    a_r9_dma_single: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({dma_src_we_o, dma_dst_we_o}));

    // R11: an undecoded halfword write raises the error pulse next cycle
    a_r11_err_on_hole: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wr_size_i == 2'd1 && !is_valid(addr_i[ADDR_W-1:1])) |=> err_o);

    // R8: key reads return the inverted live levels
    a_r8_key_read: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_en_i && !wr_en_i && addr_i[ADDR_W-1:1] == idx_t'(IX_KEYS))
        |=> rdata_o == (16'h03FF ^ {6'b0, $past(keys_i)}));

endmodule

// File: tb/iobank_regs_bench.sv
`timescale 1ns/1ps
module iobank_regs_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_size;
    logic        rd_en;
    logic [6:0]  addr;
    logic [31:0] wdata;
    logic [15:0] irq_raise;
    logic [9:0]  keys;
    logic [15:0] rdata;
    logic        err;
    logic        halt_req;
    logic [3:0]  src_we;
    logic [3:0]  dst_we;
    logic [31:0] dma_addr;
    logic [3:0]  tmr_we;
    logic [15:0] tmr_val;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    logic [15:0] mdl [64];

    always #4 clk = ~clk;

    iobank_regs u_iobank_regs (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_size_i(wr_size),
        .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata), .irq_raise_i(irq_raise),
        .keys_i(keys), .rdata_o(rdata), .err_o(err), .halt_req_o(halt_req),
        .dma_src_we_o(src_we), .dma_dst_we_o(dst_we), .dma_addr_o(dma_addr),
        .tmr_reload_we_o(tmr_we), .tmr_reload_o(tmr_val)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic bit m_dma(int i);
        return i >= 8 && i < 40 && ((i - 8) % 8) < 6;
    endfunction

    function automatic bit m_valid(int i);
        return m_dma(i) || (i >= 40 && i <= 49) || i <= 2 || (i >= 56 && i <= 58);
    endfunction

    function automatic logic [15:0] m_mask(int i);
        if (i == 1)                         return 16'hFFF8;
        if (i >= 40 && i < 48 && (i % 2))   return 16'h00C7;
        if (i == 48)                        return 16'hC1FF;
        if (i == 58)                        return 16'h0001;
        return 16'hFFFF;
    endfunction

    function automatic void m_apply(int i, logic [15:0] v);
        if (i == 57)      mdl[i] = mdl[i] & ~v;
        else if (i != 49) mdl[i] = v & m_mask(i);
    endfunction

    task automatic do_write(string tag, int sz, logic [6:0] a, logic [31:0] d, logic [15:0] rs);
        logic        e_halt = 1'b0, e_err = 1'b0;
        logic [3:0]  e_src = '0, e_dst = '0, e_tmr = '0;
        logic [31:0] e_addr = '0;
        logic [15:0] e_tval = '0, v0, v1, cur;
        int i0;
        bit two;
        @(negedge clk);
        wr_en = 1'b1; wr_size = 2'(sz); addr = a; wdata = d; irq_raise = rs;
        if (sz == 0 && a == 7'h7F) begin
            e_halt = !d[7];
        end else begin
            two = (sz == 2);
            i0  = two ? int'(a[6:2]) * 2 : int'(a[6:1]);
            cur = mdl[i0];
            if (sz == 0) v0 = a[0] ? {d[7:0], cur[7:0]} : {cur[15:8], d[7:0]};
            else         v0 = d[15:0];
            v1 = d[31:16];
            e_err = !m_valid(i0) || (two && !m_valid(i0 + 1));
            if (m_dma(i0) && ((i0 - 8) % 8) < 4) begin
                if (two)          e_addr = {v1, v0};
                else if (!i0[0])  e_addr = {mdl[i0 + 1], v0};
                else              e_addr = {v0, mdl[i0 - 1]};
                if (((i0 - 8) % 8) < 2) e_src = 4'(1) << ((i0 - 8) / 8);
                else                    e_dst = 4'(1) << ((i0 - 8) / 8);
            end
            if (i0 >= 40 && i0 < 48 && !i0[0]) begin
                e_tmr  = 4'(1) << ((i0 - 40) / 2);
                e_tval = v0;
            end
            m_apply(i0, v0);
            if (two) m_apply(i0 + 1, v1);
        end
        mdl[57] = mdl[57] | rs;
        @(negedge clk);
        wr_en = 1'b0; irq_raise = '0;
        chk({tag, " R6 halt"}, 32'(halt_req), 32'(e_halt));
        chk({tag, " R11 err"}, 32'(err), 32'(e_err));
        chk({tag, " R9 strobes"}, {24'b0, src_we, dst_we}, {24'b0, e_src, e_dst});
        if (e_src != 0 || e_dst != 0) chk({tag, " R9 addr"}, dma_addr, e_addr);
        chk({tag, " R4 tstrobe"}, 32'(tmr_we), 32'(e_tmr));
        if (e_tmr != 0) chk({tag, " R4 tval"}, 32'(tmr_val), 32'(e_tval));
    endtask

    task automatic do_read(string tag, logic [6:0] a);
        int i = int'(a[6:1]);
        logic [15:0] e;
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        if (i == 49)                         e = 16'h03FF ^ {6'b0, keys};
        else if (m_dma(i) && (i - 8) % 8 == 4) e = 16'h0000;
        else                                 e = mdl[i];
        @(negedge clk);
        rd_en = 1'b0;
        chk({tag, " R12 rdata"}, 32'(rdata), 32'(e));
        chk({tag, " R11 rd err"}, 32'(err), 32'(!m_valid(i)));
        chk({tag, " R12 no strobe"}, {18'b0, halt_req, tmr_we, src_we, dst_we}, 32'h0);
    endtask

    initial begin
        rst = 1'b1; wr_en = 0; wr_size = 0; rd_en = 0; addr = 0; wdata = 0;
        irq_raise = 0; keys = 0;
        for (int i = 0; i < 64; i++) mdl[i] = 16'h0000;
        mdl[0] = 16'h0080; mdl[2] = 16'h0200; mdl[49] = 16'h03FF;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset strobes", {22'b0, err, halt_req, src_we, dst_we}, 32'h0);
        do_read("R1 ctrl", 7'h00);
        do_read("R1 bias", 7'h04);
        do_read("R1 irq flags", 7'h72);
        do_read("R8 keys idle", 7'h62);
        keys = 10'h005;
        do_read("R8 keys pressed", 7'h62);
        do_write("R8 key write", 1, 7'h62, 32'h0000_1234, 16'h0);
        do_read("R8 key after write", 7'h62);
        do_write("R2 stat", 1, 7'h02, 32'h0000_FFFF, 16'h0);
        do_read("R2 stat rb", 7'h02);
        do_write("R3 raise", 1, 7'h70, 32'h0000_1234, 16'h00F0);
        do_read("R3 after raise", 7'h72);
        do_write("R3 w1c", 1, 7'h72, 32'h0000_0030, 16'h0);
        do_read("R3 after clear", 7'h72);
        do_write("R3 raise wins", 1, 7'h72, 32'h0000_0001, 16'h0001);
        do_read("R3 raise wins rb", 7'h72);
        do_write("R4 tctl", 1, 7'h52, 32'h0000_FFFF, 16'h0);
        do_read("R4 tctl rb", 7'h52);
        do_write("R4 reload", 1, 7'h54, 32'h0000_BEEF, 16'h0);
        do_write("R5 byte hi", 0, 7'h01, 32'h0000_00AB, 16'h0);
        do_read("R5 byte hi rb", 7'h00);
        do_write("R5 byte lo", 0, 7'h00, 32'h0000_0012, 16'h0);
        do_read("R5 byte lo rb", 7'h00);
        do_write("R6 halt go", 0, 7'h7F, 32'h0000_0000, 16'h0);
        do_write("R6 halt ignored", 0, 7'h7F, 32'h0000_0080, 16'h0);
        do_read("R6 port untouched", 7'h7E);
        do_write("R7 cnt", 1, 7'h18, 32'h0000_1234, 16'h0);
        do_read("R7 cnt rb", 7'h18);
        do_read("R7 cnt3 rb", 7'h48);
        do_write("R9 src hi", 1, 7'h12, 32'h0000_0800, 16'h0);
        do_write("R9 src lo", 1, 7'h10, 32'h0000_1000, 16'h0);
        do_write("R9 dst word", 2, 7'h24, 32'hDEAD_BEEF, 16'h0);
        do_read("R9 dst hi rb", 7'h26);
        do_write("R9 byte dst3", 0, 7'h47, 32'h0000_0077, 16'h0);
        do_write("R10 ser", 1, 7'h60, 32'h0000_FFFF, 16'h0);
        do_read("R10 ser rb", 7'h60);
        do_write("R10 master", 1, 7'h74, 32'h0000_FFFF, 16'h0);
        do_read("R10 master rb", 7'h74);
        do_write("R11 hole", 1, 7'h06, 32'h0000_5555, 16'h0);
        do_read("R11 hole rb", 7'h06);
        do_write("R5 word split", 2, 7'h70, 32'h00FF_4321, 16'h0);
        do_read("R5 word lo rb", 7'h70);
        do_read("R5 word hi rb", 7'h72);
        // R12: simultaneous read and write performs only the write
        @(negedge clk);
        wr_en = 1; rd_en = 1; wr_size = 2'd1; addr = 7'h00; wdata = 32'h0000_CAFE;
        mdl[0] = 16'hCAFE;
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        chk("R12 write wins holds rdata", 32'(rdata), 32'h0000_0200 ^ 32'h0000_0200 ^ 32'(16'h0));
        do_read("R12 write wins rb", 7'h00);

        void'($urandom(32'd1234));
        for (int n = 0; n < 400; n++) begin
            logic [6:0] ra = 7'($urandom_range(0, 127));
            if ($urandom_range(0, 1) == 1) begin
                keys = 10'($urandom);
                do_read("rand", ra);
            end else begin
                int sz = $urandom_range(0, 2);
                logic [15:0] rs = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0;
                do_write("rand", sz, ra, $urandom, rs);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule